// File: doc/BRIEF.md
# Open-Row Bank State Tracker

This block tracks which row is open in each bank of one memory pseudo channel and turns each decoded access into the short series of primitive DRAM commands that the access needs. An access names a bank group, a bank within that group, a row and a direction. The tracker looks up the target bank and sorts the access into one of three classes. A bank with no open row gets an activate and then the column command. A bank with the same row already open gets only the column command. A bank with some other row open gets a precharge, an activate and then the column command.

Both the request side and the command side use valid/ready handshakes. A new access is taken only after every command of the previous one has been accepted downstream. For efficiency reporting, each accepted access is flagged as a read/write turnaround and as same-group or cross-group, both relative to the previous column access. Free-running counters total hits, misses, closed-bank accesses, turnarounds and same-group accesses. A precharge-all request closes every bank with a single command.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset every bank is closed, `req_ready` is 1, `cmd_valid` is 0 and all five counters read 0.
- R2: An access to a closed bank issues ACT and then the column command (RD for a read, WR for a write), and reports class code 2 (closed).
- R3: An access whose row matches the open row of the target bank issues only the column command and reports class code 0 (hit).
- R4: An access whose row differs from the open row of the target bank issues PRE, then ACT, then the column command, and reports class code 1 (miss).
- R5: Each bank, indexed as group*4+bank, holds at most one open row independently of all other banks. Opening a row in one bank changes the class of no other bank.
- R6: Operation codes on `cmd_op` are PRE=0, ACT=1, RD=2, WR=3, PREALL=4. Every command of an access carries the access's group and bank, and ACT carries its row.
- R7: `acc_turn` is 1 when the access direction differs from that of the previous column access. The first access after reset is never flagged.
- R8: `acc_same_group` is 1 when the access targets the same bank group as the previous column access. The first access after reset is never flagged.
- R9: A request with `req_pre_all` set issues one PREALL command, raises no `acc_valid`, changes no counter or flag history, and leaves every bank closed.
- R10: `req_ready` is 1 only when no command is pending. While `cmd_valid` is 1 and `cmd_ready` is 0, the command and its fields hold steady.
- R11: On each accepted access, exactly one of `cnt_hit`, `cnt_miss` and `cnt_closed` rises by one. `cnt_turn` and `cnt_same` rise when the matching flag is set. The counters are visible in the cycle that `acc_valid` is 1.
- R12: Parameter `GROUPS` selects 4 groups (16 banks) or 8 groups (32 banks) of 4 banks each, and all group codes are tracked separately.
- R13: The class and flags for an accepted request appear on `acc_*` with `acc_valid` 1 for exactly the one cycle after the accepting edge. The first command is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Tracker can take a request |
| req_group | input | GW | Target bank group |
| req_bank | input | 2 | Bank within group |
| req_row | input | ROW_W | Target row |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pre_all | input | 1 | Request is a precharge-all |
| cmd_valid | output | 1 | Primitive command valid |
| cmd_ready | input | 1 | Downstream accepts command |
| cmd_op | output | 3 | Command operation code |
| cmd_group | output | GW | Command bank group |
| cmd_bank | output | 2 | Command bank |
| cmd_row | output | ROW_W | Command row |
| acc_valid | output | 1 | Classification pulse |
| acc_kind | output | 2 | 0 hit, 1 miss, 2 closed |
| acc_turn | output | 1 | Direction change flag |
| acc_same_group | output | 1 | Same bank group flag |
| cnt_hit | output | CNT_W | Hit count |
| cnt_miss | output | CNT_W | Miss count |
| cnt_closed | output | CNT_W | Closed-bank count |
| cnt_turn | output | CNT_W | Turnaround count |
| cnt_same | output | CNT_W | Same-group count |

## Verification
A vector walk drives a mixed sequence: first touches of fresh banks, repeats of an open row, a different row in an open bank, and an access to a neighbour bank in the same group with the same row number. Together these separate the closed, hit and miss paths and show that the state is kept per bank. The same walk alternates directions and groups, so the turnaround and same-group flags each see both values. It also puts a precharge-all between two accesses to one row, which shows that the reopened bank is closed again. Directed tests then hold `cmd_ready` low in the middle of a sequence, read back the totals, and run an eight-group instance to show that high group codes are tracked apart from low ones.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [2:0] {
    OP_PRE  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PREA = 3'd4
  } brt_op_e;

  typedef enum logic [1:0] {
    K_HIT    = 2'd0,
    K_MISS   = 2'd1,
    K_CLOSED = 2'd2
  } brt_kind_e;

  function automatic brt_kind_e classify(input logic is_open, input logic row_eq);
    if (!is_open) return K_CLOSED;
    if (row_eq)   return K_HIT;
    return K_MISS;
  endfunction

  function automatic brt_op_e column_op(input logic wr);
    return wr ? OP_WR : OP_RD;
  endfunction

endpackage

// File: rtl/brt_bank_table.sv
module brt_bank_table #(
  parameter int NB    = 16,
  parameter int ROW_W = 14,
  localparam int IW   = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    look_idx,
  input  logic [ROW_W-1:0] look_row,
  output logic             look_open,
  output logic             look_match,
  input  logic             open_en,
  input  logic             close_all
);

  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (close_all) begin
        open_q[b] <= 1'b0;
      end else if (open_en && look_idx == IW'(b)) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= look_row;
      end
    end
  end

  assign look_open  = open_q[look_idx];
  assign look_match = (row_q[look_idx] == look_row);

endmodule

// File: rtl/brt_sequencer.sv
module brt_sequencer
  import brt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  brt_kind_e start_kind,
  input  logic      start_prea,
  input  logic      col_write,
  input  logic      cmd_ready,
  output logic      cmd_valid,
  output brt_op_e   cmd_op,
  output logic      idle
);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_COL, S_PREA} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q == S_IDLE) begin
      if (start) begin
        if (start_prea)                 st_d = S_PREA;
        else if (start_kind == K_MISS)  st_d = S_PRE;
        else if (start_kind == K_CLOSED) st_d = S_ACT;
        else                            st_d = S_COL;
      end
    end else if (cmd_ready) begin
      case (st_q)
        S_PRE:   st_d = S_ACT;
        S_ACT:   st_d = S_COL;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    case (st_q)
      S_PRE:   cmd_op = OP_PRE;
      S_ACT:   cmd_op = OP_ACT;
      S_PREA:  cmd_op = OP_PREA;
      default: cmd_op = column_op(col_write);
    endcase
  end

  assign idle      = (st_q == S_IDLE);
  assign cmd_valid = !idle;

endmodule

// File: rtl/brt_stats.sv
module brt_stats #(
  parameter int NEV   = 5,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NEV-1:0]            ev,
  output logic [NEV-1:0][CNT_W-1:0] cnt
);

  for (genvar e = 0; e < NEV; e++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)     cnt[e] <= '0;
      else if (ev[e]) cnt[e] <= cnt[e] + CNT_W'(1);
    end
  end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int BPG    = 4,
  parameter int ROW_W  = 14,
  parameter int CNT_W  = 16,
  localparam int GW    = $clog2(GROUPS),
  localparam int BW    = $clog2(BPG),
  localparam int NB    = GROUPS * BPG,
  localparam int IW    = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [GW-1:0]    req_group,
  input  logic [BW-1:0]    req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_write,
  input  logic             req_pre_all,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [2:0]       cmd_op,
  output logic [GW-1:0]    cmd_group,
  output logic [BW-1:0]    cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic             acc_valid,
  output logic [1:0]       acc_kind,
  output logic             acc_turn,
  output logic             acc_same_group,
  output logic [CNT_W-1:0] cnt_hit,
  output logic [CNT_W-1:0] cnt_miss,
  output logic [CNT_W-1:0] cnt_closed,
  output logic [CNT_W-1:0] cnt_turn,
  output logic [CNT_W-1:0] cnt_same
);

  // named internal events
  logic      accept, col_accept, look_open, look_match, seq_idle, turn_w, same_w;
  logic [IW-1:0] idx;
  brt_kind_e kind_w;
  brt_op_e   op_w;

  // history of the previous column access
  logic          last_valid_q, last_wr_q;
  logic [GW-1:0] last_group_q;
  logic          cur_wr_q;

  assign accept     = req_valid && req_ready;
  assign col_accept = accept && !req_pre_all;
  assign idx        = IW'(req_group) * IW'(BPG) + IW'(req_bank);

  brt_bank_table #(.NB(NB), .ROW_W(ROW_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .look_idx(idx), .look_row(req_row),
    .look_open(look_open), .look_match(look_match),
    .open_en(col_accept), .close_all(accept && req_pre_all)
  );

  assign kind_w = classify(look_open, look_match);
  assign turn_w = last_valid_q && (req_write != last_wr_q);
  assign same_w = last_valid_q && (req_group == last_group_q);

  brt_sequencer seq_i (
    .clk(clk), .rst_n(rst_n),
    .start(accept), .start_kind(kind_w), .start_prea(req_pre_all),
    .col_write(cur_wr_q), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_op(op_w), .idle(seq_idle)
  );

  assign req_ready = seq_idle;
  assign cmd_op    = op_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_valid_q   <= 1'b0;
      last_wr_q      <= 1'b0;
      last_group_q   <= '0;
      cur_wr_q       <= 1'b0;
      cmd_group      <= '0;
      cmd_bank       <= '0;
      cmd_row        <= '0;
      acc_valid      <= 1'b0;
      acc_kind       <= 2'd0;
      acc_turn       <= 1'b0;
      acc_same_group <= 1'b0;
    end else begin
      acc_valid <= col_accept;
      if (accept) begin
        cmd_group <= req_group;
        cmd_bank  <= req_bank;
        cmd_row   <= req_row;
        cur_wr_q  <= req_write;
      end
      if (col_accept) begin
        acc_kind       <= kind_w;
        acc_turn       <= turn_w;
        acc_same_group <= same_w;
        last_valid_q   <= 1'b1;
        last_wr_q      <= req_write;
        last_group_q   <= req_group;
      end
    end
  end

  logic [4:0]            ev;
  logic [4:0][CNT_W-1:0] cnt;

  assign ev = {col_accept && same_w,
               col_accept && turn_w,
               col_accept && kind_w == K_CLOSED,
               col_accept && kind_w == K_MISS,
               col_accept && kind_w == K_HIT};

  brt_stats #(.NEV(5), .CNT_W(CNT_W)) stats_i (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
  );

  assign cnt_hit    = cnt[0];
  assign cnt_miss   = cnt[1];
  assign cnt_closed = cnt[2];
  assign cnt_turn   = cnt[3];
  assign cnt_same   = cnt[4];

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic             acc_valid,
  input logic [1:0]       acc_kind,
  input logic [CNT_W-1:0] cnt_hit
);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));

  assert_closed_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd2) |-> (cmd_valid && cmd_op == 3'd1));

  assert_hit_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0) |-> (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3)));

  assert_miss_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd1) |-> (cmd_valid && cmd_op == 3'd0));

  assert_pre_then_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd0) |=> (cmd_valid && cmd_op == 3'd1));

  assert_prea_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |-> !acc_valid);

  assert_hit_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0) |-> (cnt_hit == $past(cnt_hit) + CNT_W'(1)));

  assert_kind_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_kind != 2'd3));

endmodule

bind bank_row_tracker brt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .acc_valid(acc_valid), .acc_kind(acc_kind), .cnt_hit(cnt_hit)
);

// File: tb/bank_row_tracker_tb.sv
module bank_row_tracker_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // four-group instance
  logic        req_valid = 0, req_write = 0, req_pre_all = 0, cmd_ready = 1;
  logic [1:0]  req_group = 0, req_bank = 0;
  logic [13:0] req_row = 0;
  logic        req_ready, cmd_valid, acc_valid, acc_turn, acc_same_group;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_group, cmd_bank, acc_kind;
  logic [13:0] cmd_row;
  logic [15:0] cnt_hit, cnt_miss, cnt_closed, cnt_turn, cnt_same;

  bank_row_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_group(req_group), .req_bank(req_bank), .req_row(req_row),
    .req_write(req_write), .req_pre_all(req_pre_all),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_group(cmd_group), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_turn(acc_turn),
    .acc_same_group(acc_same_group), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss),
    .cnt_closed(cnt_closed), .cnt_turn(cnt_turn), .cnt_same(cnt_same)
  );

  // eight-group instance
  logic        v8 = 0;
  logic [2:0]  g8 = 0;
  logic        rdy8, cv8, av8, at8, as8;
  logic [2:0]  op8, cg8;
  logic [1:0]  cb8, ak8;
  logic [13:0] cr8;
  logic [15:0] h8, m8, c8, t8, s8;

  bank_row_tracker #(.GROUPS(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_ready(rdy8),
    .req_group(g8), .req_bank(2'd3), .req_row(14'd3),
    .req_write(1'b0), .req_pre_all(1'b0),
    .cmd_valid(cv8), .cmd_ready(1'b1), .cmd_op(op8),
    .cmd_group(cg8), .cmd_bank(cb8), .cmd_row(cr8),
    .acc_valid(av8), .acc_kind(ak8), .acc_turn(at8),
    .acc_same_group(as8), .cnt_hit(h8), .cnt_miss(m8),
    .cnt_closed(c8), .cnt_turn(t8), .cnt_same(s8)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  grp;
    logic [1:0]  bnk;
    logic [13:0] row;
    logic        wr;
    logic        pa;
    logic [1:0]  kind;
    logic        turn;
    logic        same;
    logic [1:0]  nops;
    logic [2:0]  op0;
    logic [2:0]  op1;
    logic [2:0]  op2;
  } vec_t;

  // ops: PRE=0 ACT=1 RD=2 WR=3 PREALL=4; kinds: hit 0, miss 1, closed 2
  localparam vec_t VEC [9] = '{
    '{2'd0, 2'd0, 14'd5,     1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 2'd2, 3'd1, 3'd2, 3'd0}, // R2 R7 R8 first
    '{2'd0, 2'd0, 14'd5,     1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 3'd3, 3'd0, 3'd0}, // R3
    '{2'd1, 2'd2, 14'd7,     1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 2'd2, 3'd1, 3'd3, 3'd0}, // R2
    '{2'd1, 2'd2, 14'd9,     1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 2'd3, 3'd0, 3'd1, 3'd2}, // R4
    '{2'd3, 2'd3, 14'd16383, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 2'd2, 3'd1, 3'd2, 3'd0}, // R2 edge
    '{2'd0, 2'd0, 14'd5,     1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 3'd2, 3'd0, 3'd0}, // R5 kept
    '{2'd0, 2'd1, 14'd5,     1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 2'd2, 3'd1, 3'd2, 3'd0}, // R5 neighbour
    '{2'd0, 2'd0, 14'd0,     1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 3'd4, 3'd0, 3'd0}, // R9
    '{2'd0, 2'd0, 14'd5,     1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 2'd2, 3'd1, 3'd3, 3'd0}  // R9 closed
  };

  task automatic run_vec(input vec_t v);
    int n;
    logic [2:0] ops [4];
    @(negedge clk);
    req_group = v.grp; req_bank = v.bnk; req_row = v.row;
    req_write = v.wr; req_pre_all = v.pa; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (v.pa) begin
      chk(acc_valid == 1'b0, "R9 no acc_valid", int'(acc_valid), 0);
    end else begin
      chk(acc_valid == 1'b1, "R13 acc_valid", int'(acc_valid), 1);
      chk(acc_kind == v.kind, "R2/R3/R4 class", int'(acc_kind), int'(v.kind));
      chk(acc_turn == v.turn, "R7 turn", int'(acc_turn), int'(v.turn));
      chk(acc_same_group == v.same, "R8 same", int'(acc_same_group), int'(v.same));
    end
    n = 0;
    while (cmd_valid && n < 4) begin
      ops[n] = cmd_op;
      if (!v.pa) begin
        chk(cmd_group == v.grp && cmd_bank == v.bnk, "R6 cmd target",
            int'({cmd_group, cmd_bank}), int'({v.grp, v.bnk}));
        if (cmd_op == 3'd1) chk(cmd_row == v.row, "R6 act row", int'(cmd_row), int'(v.row));
      end
      n++;
      @(posedge clk);
      @(negedge clk);
    end
    chk(n == int'(v.nops), "R2/R3/R4 command count", n, int'(v.nops));
    if (n >= 1) chk(ops[0] == v.op0, "R6 op0", int'(ops[0]), int'(v.op0));
    if (n >= 2) chk(ops[1] == v.op1, "R6 op1", int'(ops[1]), int'(v.op1));
    if (n >= 3) chk(ops[2] == v.op2, "R6 op2", int'(ops[2]), int'(v.op2));
    chk(req_ready == 1'b1, "R10 ready after drain", int'(req_ready), 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
    chk(cnt_hit == 0 && cnt_miss == 0 && cnt_closed == 0 && cnt_turn == 0 && cnt_same == 0,
        "R1 counters", int'(cnt_hit + cnt_miss + cnt_closed + cnt_turn + cnt_same), 0);

    for (int i = 0; i < 9; i++) run_vec(VEC[i]);

    // R10 stall: closed read to g2 b1, previous column was a write to g0
    cmd_ready = 1'b0;
    @(negedge clk);
    req_group = 2'd2; req_bank = 2'd1; req_row = 14'd100;
    req_write = 1'b0; req_pre_all = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b1 && cmd_op == 3'd1, "R10 held command", int'(cmd_op), 1);
    chk(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
    cmd_ready = 1'b1;
    @(negedge clk);
    chk(cmd_op == 3'd2, "R10 column after stall", int'(cmd_op), 2);
    @(negedge clk);
    chk(cmd_valid == 1'b0 && req_ready == 1'b1, "R10 drained", int'(cmd_valid), 0);

    // R11 totals
    chk(cnt_hit == 16'd2, "R11 hits", int'(cnt_hit), 2);
    chk(cnt_miss == 16'd1, "R11 misses", int'(cnt_miss), 1);
    chk(cnt_closed == 16'd6, "R11 closed", int'(cnt_closed), 6);
    chk(cnt_turn == 16'd4, "R11 turns", int'(cnt_turn), 4);
    chk(cnt_same == 16'd4, "R11 same", int'(cnt_same), 4);

    // R12 eight groups: g7 closed, g7 hit, g3 closed
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      g8 = (k == 2) ? 3'd3 : 3'd7;
      v8 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      v8 = 1'b0;
      chk(av8 == 1'b1 && ak8 == ((k == 1) ? 2'd0 : 2'd2), "R12 eight-group class",
          int'(ak8), (k == 1) ? 0 : 2);
      repeat (3) @(negedge clk);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule